// File: doc/BRIEF.md
# Clause-22 Management Frame Master

This block runs the station-management (MDC/MDIO) link to an external PHY. Software writes one 32-bit command word into the command register and the block sends the whole frame by itself. The frame is a preamble of ones followed by the 32 command bits. The command word holds the start pattern, the opcode, the PHY address, the register address, the turnaround bits and, for a write, 16 data bits. When the opcode asks for a read, the block releases MDIO once the register address has been sent. It then shifts in the PHY's 16-bit answer and places it in the low half of the command register.

A separate divider register sets the clock rate: MDC runs at the system clock divided by twice the divider value. A divider value of zero freezes MDC. Every finished frame raises a sticky completion flag, which software clears by writing a one to its bit.

All register accesses are plain write strobes with no back-pressure. Writing the command register while a frame is in progress is refused silently: the write is dropped and the stored word stays as it was. The MDIO pin is split into an output, an output enable and an input, so a tri-state pad or an open-drain pad can sit outside the block.

Top module: `mdio_master`

## Requirements
- R1: A command write while idle launches one frame: 32 ones, then the command word from bit 31 down to bit 0. The field layout is [31:30] start, [29:28] opcode, [27:23] PHY address, [22:18] register address, [17:16] turnaround and [15:0] data.
- R2: MDC is low while idle. During a frame, each MDC period lasts 2*N system clocks (N low, then N high), where N is the divider value, and a frame takes exactly 64 MDC rising edges.
- R3: MDIO output and enable change only together with an MDC falling edge or at launch, so they are steady through every high phase.
- R4: Opcode 2'b10 is a read: the block drives the first 46 bits and holds mdio_oe low for the last 18 bits. Any other opcode drives all 64 bits.
- R5: After a read, cmd_q[15:0] holds the bits sampled on the last 16 MDC rising edges, first-received bit at position 15. cmd_q[31:16] is unchanged.
- R6: busy is high from the cycle after launch until the frame ends. The end of a frame sets evt_q[23].
- R7: Writing evt_wdata with bit 23 set clears evt_q[23]. A write with bit 23 clear leaves the flag as it is. If a set and a clear fall in the same cycle, the set wins.
- R8: A command write while busy is dropped: cmd_q does not change, the running frame is unaffected, and no second frame follows.
- R9: While the divider value is 0, MDC holds its level and a pending frame stalls with busy high. The frame resumes once the divider becomes nonzero.
- R10: After reset, busy, mdc, mdio_oe, evt_q and cmd_q are all 0, and the divider value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word |
| cmd_q | output | 32 | Command register contents, read data in the low half after a read |
| div_we | input | 1 | Divider register write strobe |
| div_wdata | input | DIV_W | Divider value N |
| evt_we | input | 1 | Event register write strobe (write-1-to-clear) |
| evt_wdata | input | 32 | Clear mask |
| evt_q | output | 32 | Event register, completion flag at bit 23 |
| busy | output | 1 | Frame in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench builds the block with its default parameters: a 6-bit divider, a 32-bit preamble and the event at bit 23. It switches the divider between 1, 2 and 3, which covers the shortest legal high phase as well as multi-cycle phases. A PHY model in the bench answers reads with two different data patterns. A divider of 0 set during a pending frame exercises the stall and resume path. A command write placed mid-frame shows that no second frame appears.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    OP_WR = 2'b01,
    OP_RD = 2'b10
  } mdio_op_e;

  typedef struct packed {
    logic [1:0]  start;
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [1:0]  ta;
    logic [15:0] data;
  } mdio_cmd_t;

  localparam int CMD_W      = 32;
  localparam int DATA_W     = 16;
  // bits driven by the master before release in a read: start+op+phy+reg
  localparam int RD_HDR_W   = 14;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt;
  logic             mdc_q;
  logic             div_ok;
  logic             tick;

  assign div_ok = (div != '0);
  assign tick   = en && div_ok && (cnt >= (div - ONE));
  assign rise   = tick && !mdc_q;
  assign fall   = tick && mdc_q;
  assign mdc    = mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (!en) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt   <= '0;
      mdc_q <= !mdc_q;
    end else if (div_ok) begin
      cnt   <= cnt + ONE;
    end
  end
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic              is_rd,
  output logic [DATA_W-1:0] rd_data
);
  localparam int FRAME_BITS = PRE_BITS + CMD_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] RELEASE_AT = CNT_W'(PRE_BITS + RD_HDR_W);
  localparam logic [CNT_W-1:0] SAMPLE_AT  = CNT_W'(FRAME_BITS - DATA_W);

  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0]      bitcnt;
  logic                  busy_q;
  logic                  rd_q;
  logic [DATA_W-1:0]     cap;
  mdio_cmd_t             cmd_s;

  assign cmd_s   = mdio_cmd_t'(cmd);
  assign busy    = busy_q;
  assign is_rd   = rd_q;
  assign rd_data = cap;
  assign mdio_o  = shreg[FRAME_BITS-1];
  assign mdio_oe = busy_q && !(rd_q && (bitcnt >= RELEASE_AT));
  assign done    = busy_q && fall && (bitcnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      bitcnt <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      cap    <= '0;
    end else if (!busy_q) begin
      if (launch) begin
        shreg  <= {{PRE_BITS{1'b1}}, cmd};
        bitcnt <= '0;
        busy_q <= 1'b1;
        rd_q   <= (cmd_s.op == OP_RD);
        cap    <= '0;
      end
    end else begin
      if (rise && rd_q && (bitcnt >= SAMPLE_AT))
        cap <= {cap[DATA_W-2:0], mdio_i};
      if (fall) begin
        if (bitcnt == LAST_BIT) begin
          busy_q <= 1'b0;
        end else begin
          bitcnt <= bitcnt + CNT_W'(1);
          shreg  <= {shreg[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_evt.sv
module mdio_evt #(
  parameter int W       = 32,
  parameter int EVT_BIT = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] evt_q
);
  logic flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag <= 1'b0;
    else if (set)
      flag <= 1'b1;
    else if (clr_we && clr_mask[EVT_BIT])
      flag <= 1'b0;
  end

  for (genvar g = 0; g < W; g++) begin : g_bit
    if (g == EVT_BIT) begin : g_live
      assign evt_q[g] = flag;
    end else begin : g_zero
      assign evt_q[g] = 1'b0;
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 6,
  parameter int PRE_BITS = 32,
  parameter int EVT_BIT  = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [31:0]      cmd_wdata,
  output logic [31:0]      cmd_q,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             evt_we,
  input  logic [31:0]      evt_wdata,
  output logic [31:0]      evt_q,
  output logic             busy,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic [DIV_W-1:0]  div_q;
  logic              rise, fall;
  logic              done, is_rd;
  logic [DATA_W-1:0] rd_data;
  logic              launch;

  assign launch = cmd_we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (div_we) div_q <= div_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cmd_q <= '0;
    else if (launch)
      cmd_q <= cmd_wdata;
    else if (done && is_rd)
      cmd_q[DATA_W-1:0] <= rd_data;
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(busy), .div(div_q),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_seq #(.PRE_BITS(PRE_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .cmd(cmd_wdata),
    .rise(rise), .fall(fall), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done), .is_rd(is_rd), .rd_data(rd_data)
  );

  mdio_evt #(.W(32), .EVT_BIT(EVT_BIT)) u_evt (
    .clk(clk), .rst_n(rst_n), .set(done), .clr_we(evt_we),
    .clr_mask(evt_wdata), .evt_q(evt_q)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int DIV_W   = 6,
  parameter int EVT_BIT = 23
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic [31:0]      cmd_q,
  input logic [31:0]      evt_q,
  input logic [DIV_W-1:0] div_q
);
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R2

  AST_OE_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe); // R4

  AST_MDIO_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R3

  AST_EVT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> evt_q[EVT_BIT]); // R6

  AST_CMD_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_q)); // R8

  AST_MDC_FROZEN_DIV0: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(div_q) == '0) |-> $stable(mdc)); // R9
endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W), .EVT_BIT(EVT_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .cmd_q(cmd_q), .evt_q(evt_q), .div_q(div_q)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  localparam int DIV_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_we = 1'b0;
  logic [31:0]      cmd_wdata = '0;
  logic [31:0]      cmd_q;
  logic             div_we = 1'b0;
  logic [DIV_W-1:0] div_wdata = '0;
  logic             evt_we = 1'b0;
  logic [31:0]      evt_wdata = '0;
  logic [31:0]      evt_q;
  logic             busy, mdc, mdio_o, mdio_oe;
  logic             mdio_i = 1'b1;

  always #5 clk = !clk;

  mdio_master u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_q(cmd_q), .div_we(div_we), .div_wdata(div_wdata), .evt_we(evt_we),
    .evt_wdata(evt_wdata), .evt_q(evt_q), .busy(busy), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int nchk = 0;
  int nerr = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // PHY model and line monitor
  logic [63:0] hist;
  int  rises, oe_rises, bad_hold;
  time last_rise, dmin, dmax;
  logic last_line;
  logic [15:0] phy_val;

  always @(posedge mdc) begin
    logic line;
    line = mdio_oe ? mdio_o : mdio_i;
    if (rises < 64) hist[63-rises] = line;
    if (rises > 0) begin
      if (($time - last_rise) < dmin) dmin = $time - last_rise;
      if (($time - last_rise) > dmax) dmax = $time - last_rise;
    end
    last_rise = $time;
    last_line = mdio_o;
    if (mdio_oe) oe_rises++;
    rises++;
  end

  always @(negedge mdc) begin
    if (rises == 47) mdio_i = 1'b0;
    else if (rises >= 48 && rises <= 63) mdio_i = phy_val[63-rises];
    else mdio_i = 1'b1;
  end

  always @(negedge clk)
    if (rst_n && mdc && mdio_oe && (mdio_o !== last_line)) bad_hold++;

  typedef struct {
    logic [63:0] bits;
    int          ndrv;
    int          half;
    logic [31:0] cmd_after;
  } exp_t;
  exp_t q[$];

  // monitor: checks each finished frame against the scoreboard
  initial begin
    forever begin
      @(negedge busy);
      if (rst_n === 1'b1) begin
        #1;
        if (q.size() == 0) begin
          chk(1'b0, "R8", "unexpected frame", 64'(rises), 64'd0);
        end else begin
          exp_t e;
          logic [63:0] mask;
          e = q.pop_front();
          mask = ~(64'hFFFF_FFFF_FFFF_FFFF >> e.ndrv);
          chk((hist & mask) == (e.bits & mask), "R1", "frame bits", hist & mask, e.bits & mask);
          chk(rises == 64, "R2", "rising edges", 64'(rises), 64'd64);
          chk(dmin == dmax && dmax == time'(20 * e.half), "R2", "mdc period ns",
              64'(dmax), 64'(20 * e.half));
          chk(oe_rises == e.ndrv, "R4", "driven bits", 64'(oe_rises), 64'(e.ndrv));
          chk(bad_hold == 0, "R3", "mdio moved while mdc high", 64'(bad_hold), 64'd0);
          chk(cmd_q == e.cmd_after, "R5", "cmd_q after frame", 64'(cmd_q), 64'(e.cmd_after));
          chk(evt_q[23] == 1'b1, "R6", "event bit 23", 64'(evt_q), 64'h0080_0000);
        end
      end
    end
  end

  task automatic set_div(input int n);
    @(negedge clk); div_we = 1'b1; div_wdata = DIV_W'(n);
    @(negedge clk); div_we = 1'b0;
  endtask

  task automatic wr_evt(input logic [31:0] m);
    @(negedge clk); evt_we = 1'b1; evt_wdata = m;
    @(negedge clk); evt_we = 1'b0;
  endtask

  // driver: pushes the expectation, arms the PHY model, launches
  task automatic launch(input logic [31:0] c, input logic [15:0] rv, input int n);
    exp_t e;
    bit rd;
    rd = (c[29:28] == 2'b10);
    e.bits = {32'hFFFF_FFFF, c};
    e.ndrv = rd ? 46 : 64;
    e.half = n;
    e.cmd_after = rd ? {c[31:16], rv} : c;
    q.push_back(e);
    phy_val = rv; rises = 0; oe_rises = 0; bad_hold = 0;
    dmin = 64'hFFFF_FFFF; dmax = 0; hist = '0;
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = c;
    @(negedge clk); cmd_we = 1'b0;
    chk(busy == 1'b1, "R6", "busy after launch", 64'(busy), 64'd1);
  endtask

  task automatic finish_frame();
    wait (busy == 1'b0);
    repeat (3) @(negedge clk);
  endtask

  localparam logic [31:0] WR_A = {2'b01, 2'b01, 5'd1, 5'd4, 2'b10, 16'hBEEF};
  localparam logic [31:0] WR_B = {2'b01, 2'b01, 5'd9, 5'd7, 2'b10, 16'h1234};
  localparam logic [31:0] RD_A = {2'b01, 2'b10, 5'd5, 5'd2, 2'b11, 16'h0000};
  localparam logic [31:0] RD_B = {2'b01, 2'b10, 5'd31, 5'd17, 2'b00, 16'hFFFF};

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy == 0 && mdc == 0 && mdio_oe == 0, "R10", "idle pins",
        {61'd0, busy, mdc, mdio_oe}, 64'd0);
    chk(cmd_q == 0 && evt_q == 0, "R10", "registers", {cmd_q, evt_q}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 write frame at divider 2
    set_div(2);
    launch(WR_A, 16'h0000, 2);
    finish_frame();

    // R7 write-0 keeps the flag, write-1 clears it
    wr_evt(32'hFF7F_FFFF);
    chk(evt_q[23] == 1'b1, "R7", "flag after zero write", 64'(evt_q), 64'h0080_0000);
    wr_evt(32'h0080_0000);
    chk(evt_q == 32'd0, "R7", "flag after one write", 64'(evt_q), 64'd0);

    // R4 R5 reads with two patterns and dividers
    set_div(3);
    launch(RD_A, 16'hA5C3, 3);
    finish_frame();
    wr_evt(32'h0080_0000);
    set_div(1);
    launch(RD_B, 16'h0001, 1);
    finish_frame();
    wr_evt(32'h0080_0000);

    // R8 write while busy is dropped
    set_div(2);
    launch(WR_A, 16'h0000, 2);
    repeat (50) @(negedge clk);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = WR_B;
    @(negedge clk); cmd_we = 1'b0;
    chk(cmd_q == WR_A, "R8", "cmd_q during frame", 64'(cmd_q), 64'(WR_A));
    finish_frame();
    repeat (300) @(negedge clk);
    chk(busy == 0 && rises == 64, "R8", "no second frame", 64'(rises), 64'd64);
    wr_evt(32'h0080_0000);

    // R9 divider zero stalls the frame
    set_div(0);
    launch(WR_B, 16'h0000, 1);
    begin
      int hi;
      hi = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (mdc || !busy) hi++;
      end
      chk(hi == 0 && rises == 0, "R9", "stalled with div 0", 64'(hi), 64'd0);
    end
    set_div(1);
    finish_frame();

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R1", "all frames seen", 64'(q.size()), 64'd0);
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #(1_000_000);
    nchk++; nerr++;
    $display("FAIL R6 watchdog expired actual=%h expected=%h", busy, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule